// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit sits at the execute stage of a processor pipeline and resolves one decoded branch per cycle. It receives the branch kind, the condition options, the condition-register bit index, the displacement, the absolute and link flags, the address of the branch itself, and the current 32-bit condition register. One cycle later it presents a registered taken decision and the address at which fetch continues. On the same edge it updates the link register and the count register, which it holds internally.

The condition combines two tests. The first is an optional decrement of the count register, followed by a test for zero or nonzero. The second is a test of one selected condition-register bit. A five-bit option field enables, disables and polarises these two tests. Targets come from one of four sources: a sign-extended 14-bit displacement, a sign-extended 24-bit displacement, the link register, or the count register. Two move ports let surrounding logic load the link and count registers directly.

Top module: `branch_resolve`

## Requirements
- R1: After reset `out_valid` is 0 and `lr` and `ctr` are 0. `out_valid` is high in the cycle after `in_valid` is sampled high and low in the cycle after it is sampled low.
- R2: `in_bi` selects condition-register bit `cr[31-in_bi]`. The register is eight 4-bit fields, field 0 in bits 31..28. Each field holds less-than, greater-than, equal and overflow-summary, starting from its most significant bit.
- R3: When option bit 4 is 1, the selected bit is ignored. Otherwise the branch needs the selected bit to equal option bit 3. Option bit 0 has no effect.
- R4: In kinds 0 (displacement) and 2 (to-link), option bit 2 = 0 decrements `ctr` by one on the output edge. The count test then uses the decremented value: taken on zero when option bit 1 is 1, and on nonzero when it is 0. When option bit 2 is 1, `ctr` is kept and the count test passes.
- R5: `out_taken` is the AND of the count test and the bit test. Kind 1 (long displacement) is always taken.
- R6: With the absolute flag 0, a taken target is `in_pc` plus the sign-extended displacement shifted left by two. Kind 0 uses `in_disp[13:0]` and kind 1 uses `in_disp[23:0]`.
- R7: With the absolute flag 1, a taken target of kind 0 or 1 is the sign-extended, shifted displacement itself.
- R8: A taken kind 2 jumps to the value `lr` held before the branch, with bits 1:0 cleared. A taken kind 3 (to-count) jumps to `ctr` with bits 1:0 cleared. Kind 3 never decrements `ctr`, and its count test always passes.
- R9: With the link flag 1, `lr` becomes `in_pc + 4` whether or not the branch is taken. With the link flag 0, `lr` is unchanged by the branch.
- R10: `mv_lr_en` / `mv_ctr_en` load their data into `lr` / `ctr` on the next edge. A branch update to the same register in the same cycle takes precedence.
- R11: A branch that is not taken gives `out_target = in_pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_kind | input | 2 | 0 short displacement, 1 long displacement, 2 to-link, 3 to-count |
| in_bo | input | 5 | Condition option field |
| in_bi | input | 5 | Condition-register bit index |
| in_disp | input | 24 | Displacement (low 14 bits for kind 0) |
| in_aa | input | 1 | Absolute target flag |
| in_lk | input | 1 | Write return address into link register |
| in_pc | input | 32 | Address of the branch |
| cr | input | 32 | Condition register |
| mv_lr_en | input | 1 | Load link register |
| mv_lr_data | input | 32 | Link register load value |
| mv_ctr_en | input | 1 | Load count register |
| mv_ctr_data | input | 32 | Count register load value |
| out_valid | output | 1 | Resolution result valid |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Next fetch address |
| lr | output | 32 | Link register |
| ctr | output | 32 | Count register |

## Verification
The assertions assume that `in_pc` is word aligned. They also assume that no move to a register is issued in the same cycle as a branch that updates that register, since the precedence rule would otherwise mask the move check. The stimulus keeps every branch address a multiple of four. It loads `lr` and `ctr` only in cycles with no branch, and it always leaves a gap cycle between a move and the branch that depends on it.

// File: rtl/brq_pkg.sv
package brq_pkg;
  typedef enum logic [1:0] {
    BK_COND     = 2'd0,
    BK_UNCOND   = 2'd1,
    BK_TO_LINK  = 2'd2,
    BK_TO_COUNT = 2'd3
  } br_kind_e;

  // option field bit positions
  localparam int OPT_NO_DEC   = 2;
  localparam int OPT_ON_ZERO  = 1;
  localparam int OPT_IGN_BIT  = 4;
  localparam int OPT_BIT_VAL  = 3;
endpackage

// File: rtl/brq_cond_eval.sv
module brq_cond_eval
  import brq_pkg::*;
#(
  parameter int CR_W   = 32,
  parameter int DATA_W = 32,
  localparam int BI_W  = $clog2(CR_W)
) (
  input  br_kind_e          kind,
  input  logic [4:1]        opt,
  input  logic [BI_W-1:0]   bi,
  input  logic [CR_W-1:0]   cr,
  input  logic [DATA_W-1:0] ctr_q,
  output logic              dec_en,
  output logic [DATA_W-1:0] ctr_next,
  output logic              taken
);
  // bit index 0 names the most significant condition bit
  logic [CR_W-1:0] cr_rev;
  genvar g;
  generate
    for (g = 0; g < CR_W; g++) begin : g_rev
      assign cr_rev[g] = cr[CR_W-1-g];
    end
  endgenerate

  logic sel_bit, count_ok, bit_ok, ctr_zero, uses_count;

  always_comb begin
    sel_bit    = cr_rev[bi];
    uses_count = (kind == BK_COND) || (kind == BK_TO_LINK);
    dec_en     = uses_count && !opt[OPT_NO_DEC];
    ctr_next   = dec_en ? (ctr_q - DATA_W'(1)) : ctr_q;
    ctr_zero   = (ctr_next == '0);
    count_ok   = !dec_en || (ctr_zero == opt[OPT_ON_ZERO]);
    bit_ok     = opt[OPT_IGN_BIT] || (sel_bit == opt[OPT_BIT_VAL]);
    taken      = (kind == BK_UNCOND) || (count_ok && bit_ok);
  end

  always_comb begin
    if (kind == BK_TO_COUNT) begin
      a_no_dec_to_count_r8 : assert (!dec_en);
    end
  end
endmodule

// File: rtl/brq_target_gen.sv
module brq_target_gen
  import brq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LI_W   = 24,
  parameter int BD_W   = 14
) (
  input  br_kind_e          kind,
  input  logic [LI_W-1:0]   disp,
  input  logic              aa,
  input  logic              taken,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr_q,
  input  logic [ADDR_W-1:0] ctr_q,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] link_val
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] bd_ext, li_ext, offset, disp_tgt, taken_tgt;

  assign bd_ext   = {{(ADDR_W-BD_W-2){disp[BD_W-1]}}, disp[BD_W-1:0], 2'b00};
  assign li_ext   = {{(ADDR_W-LI_W-2){disp[LI_W-1]}}, disp, 2'b00};
  assign link_val = pc + ADDR_W'(4);

  always_comb begin
    offset   = (kind == BK_UNCOND) ? li_ext : bd_ext;
    disp_tgt = aa ? offset : (pc + offset);
    unique case (kind)
      BK_TO_LINK:  taken_tgt = lr_q & WORD_MASK;
      BK_TO_COUNT: taken_tgt = ctr_q & WORD_MASK;
      default:     taken_tgt = disp_tgt;
    endcase
    target = taken ? taken_tgt : link_val;
  end
endmodule

// File: rtl/brq_spr_regs.sv
module brq_spr_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              link_en,
  input  logic [DATA_W-1:0] link_val,
  input  logic              dec_en,
  input  logic [DATA_W-1:0] ctr_next,
  input  logic              mv_lr_en,
  input  logic [DATA_W-1:0] mv_lr_data,
  input  logic              mv_ctr_en,
  input  logic [DATA_W-1:0] mv_ctr_data,
  output logic [DATA_W-1:0] lr_q,
  output logic [DATA_W-1:0] ctr_q
);
  logic br_link, br_dec;
  assign br_link = fire && link_en;
  assign br_dec  = fire && dec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q  <= '0;
      ctr_q <= '0;
    end else begin
      if (br_link)        lr_q <= link_val;
      else if (mv_lr_en)  lr_q <= mv_lr_data;
      if (br_dec)         ctr_q <= ctr_next;
      else if (mv_ctr_en) ctr_q <= mv_ctr_data;
    end
  end

  p_link_write_r9 : assert property (@(posedge clk) disable iff (rst)
    br_link |=> lr_q == $past(link_val));
  p_ctr_decrement_r4 : assert property (@(posedge clk) disable iff (rst)
    br_dec |=> ctr_q == $past(ctr_q) - DATA_W'(1));
  p_ctr_hold_r4 : assert property (@(posedge clk) disable iff (rst)
    (!br_dec && !mv_ctr_en) |=> $stable(ctr_q));
  p_lr_hold_r9 : assert property (@(posedge clk) disable iff (rst)
    (!br_link && !mv_lr_en) |=> $stable(lr_q));
  p_move_load_r10 : assert property (@(posedge clk) disable iff (rst)
    (mv_ctr_en && !br_dec) |=> ctr_q == $past(mv_ctr_data));
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CR_FIELDS = 8,
  parameter int LI_W      = 24,
  parameter int BD_W      = 14,
  localparam int CR_W     = CR_FIELDS * 4,
  localparam int BI_W     = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [4:0]        in_bo,
  input  logic [BI_W-1:0]   in_bi,
  input  logic [LI_W-1:0]   in_disp,
  input  logic              in_aa,
  input  logic              in_lk,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [CR_W-1:0]   cr,
  input  logic              mv_lr_en,
  input  logic [ADDR_W-1:0] mv_lr_data,
  input  logic              mv_ctr_en,
  input  logic [ADDR_W-1:0] mv_ctr_data,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [ADDR_W-1:0] lr,
  output logic [ADDR_W-1:0] ctr
);
  br_kind_e          kind;
  logic              dec_en, taken;
  logic [ADDR_W-1:0] ctr_next, target, link_val;
  logic              unused_hint;

  assign kind        = br_kind_e'(in_kind);
  assign unused_hint = in_bo[0];

  brq_cond_eval #(.CR_W(CR_W), .DATA_W(ADDR_W)) u_cond (
    .kind(kind), .opt(in_bo[4:1]), .bi(in_bi), .cr(cr), .ctr_q(ctr),
    .dec_en(dec_en), .ctr_next(ctr_next), .taken(taken)
  );

  brq_target_gen #(.ADDR_W(ADDR_W), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .kind(kind), .disp(in_disp), .aa(in_aa), .taken(taken), .pc(in_pc),
    .lr_q(lr), .ctr_q(ctr), .target(target), .link_val(link_val)
  );

  brq_spr_regs #(.DATA_W(ADDR_W)) u_spr (
    .clk(clk), .rst(rst), .fire(in_valid), .link_en(in_lk),
    .link_val(link_val), .dec_en(dec_en), .ctr_next(ctr_next),
    .mv_lr_en(mv_lr_en), .mv_lr_data(mv_lr_data),
    .mv_ctr_en(mv_ctr_en), .mv_ctr_data(mv_ctr_data),
    .lr_q(lr), .ctr_q(ctr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken  <= taken;
        out_target <= target;
      end
    end
  end

  p_valid_follow_r1 : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_uncond_taken_r5 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd1) |=> out_taken);
  p_not_taken_seq_r11 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pc[1:0] == 2'b00) |=>
      (out_taken || out_target == $past(in_pc) + ADDR_W'(4)));
  p_target_aligned_r8 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pc[1:0] == 2'b00) |=> out_target[1:0] == 2'b00);
endmodule

// File: tb/branch_resolve_tb.sv
`timescale 1ns/1ps
module branch_resolve_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic [4:0]  in_bo = '0;
  logic [4:0]  in_bi = '0;
  logic [23:0] in_disp = '0;
  logic        in_aa = 1'b0, in_lk = 1'b0;
  logic [31:0] in_pc = '0, cr = '0;
  logic        mv_lr_en = 1'b0, mv_ctr_en = 1'b0;
  logic [31:0] mv_lr_data = '0, mv_ctr_data = '0;
  logic        out_valid, out_taken;
  logic [31:0] out_target, lr, ctr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_lr = '0, m_ctr = '0;

  always #10 clk = ~clk;

  branch_resolve u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_bo(in_bo), .in_bi(in_bi), .in_disp(in_disp), .in_aa(in_aa),
    .in_lk(in_lk), .in_pc(in_pc), .cr(cr), .mv_lr_en(mv_lr_en),
    .mv_lr_data(mv_lr_data), .mv_ctr_en(mv_ctr_en), .mv_ctr_data(mv_ctr_data),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .lr(lr), .ctr(ctr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctr(input logic [31:0] v);
    @(negedge clk); mv_ctr_en = 1'b1; mv_ctr_data = v;
    @(negedge clk); mv_ctr_en = 1'b0;
    m_ctr = v;
  endtask

  task automatic set_lr(input logic [31:0] v);
    @(negedge clk); mv_lr_en = 1'b1; mv_lr_data = v;
    @(negedge clk); mv_lr_en = 1'b0;
    m_lr = v;
  endtask

  // drive one branch, predict from the requirements, compare the next cycle
  task automatic fire(input logic [1:0] k, input logic [4:0] bo, input logic [4:0] bi,
                      input logic [23:0] d, input logic aa, input logic lk,
                      input logic [31:0] pc, input logic [31:0] crv, input string tag);
    logic bitv, dec, cnt_ok, bit_ok, tk;
    logic [31:0] nctr, off, tgt, nlr;
    bitv   = crv[31 - int'(bi)];
    dec    = (k == 2'd0 || k == 2'd2) && !bo[2];
    nctr   = dec ? m_ctr - 32'd1 : m_ctr;
    cnt_ok = !dec || ((nctr == 32'd0) == bo[1]);
    bit_ok = bo[4] || (bitv == bo[3]);
    tk     = (k == 2'd1) || (cnt_ok && bit_ok);
    off    = (k == 2'd1) ? {{6{d[23]}}, d, 2'b00} : {{16{d[13]}}, d[13:0], 2'b00};
    case (k)
      2'd2:    tgt = m_lr & 32'hFFFF_FFFC;
      2'd3:    tgt = m_ctr & 32'hFFFF_FFFC;
      default: tgt = aa ? off : pc + off;
    endcase
    if (!tk) tgt = pc + 32'd4;
    nlr = lk ? pc + 32'd4 : m_lr;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_bo = bo; in_bi = bi; in_disp = d;
    in_aa = aa; in_lk = lk; in_pc = pc; cr = crv;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " R1 valid"}, 32'(out_valid), 32'd1);
    chk(out_taken === tk, {tag, " R5 taken"}, 32'(out_taken), 32'(tk));
    chk(out_target === tgt, {tag, " R6 target"}, out_target, tgt);
    chk(ctr === nctr, {tag, " R4 ctr"}, ctr, nctr);
    chk(lr === nlr, {tag, " R9 lr"}, lr, nlr);
    m_ctr = nctr; m_lr = nlr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
    chk(lr === 32'd0, "R1 reset lr", lr, 32'd0);
    chk(ctr === 32'd0, "R1 reset ctr", ctr, 32'd0);

    // R10 move ports
    set_ctr(32'h0000_1234);
    chk(ctr === 32'h0000_1234, "R10 ctr move", ctr, 32'h0000_1234);
    set_lr(32'h0040_0101);
    chk(lr === 32'h0040_0101, "R10 lr move", lr, 32'h0040_0101);

    // R2/R3/R4/R5: sweep every option code, both bit values, count 1 and 2
    for (int bo = 0; bo < 32; bo++) begin
      for (int bv = 0; bv < 2; bv++) begin
        for (int c = 1; c <= 2; c++) begin
          logic [4:0]  bi;
          logic [31:0] crv;
          bi  = 5'((bo * 7 + bv * 3 + c) % 32);
          crv = 32'h5A3C_96E1 ^ (32'(bo) * 32'h0101_0101);
          crv[31 - int'(bi)] = bv[0];
          set_ctr(32'(c));
          fire(2'd0, 5'(bo), bi, 24'(bo * 13), 1'b0, 1'b0,
               32'h0001_0000 + 32'(bo * 64), crv, "sweep R3 R4");
        end
      end
    end

    // R2: field order, bit 0 is field 0 less-than, bit 31 is field 7 overflow-summary
    fire(2'd0, 5'd12, 5'd0, 24'd8, 1'b0, 1'b0, 32'h100, 32'h8000_0000, "R2 bit0 set");
    fire(2'd0, 5'd12, 5'd1, 24'd8, 1'b0, 1'b0, 32'h100, 32'h8000_0000, "R2 bit1 clear");
    fire(2'd0, 5'd12, 5'd31, 24'd8, 1'b0, 1'b0, 32'h100, 32'h0000_0001, "R2 bit31 set");
    fire(2'd0, 5'd12, 5'd6, 24'd8, 1'b0, 1'b0, 32'h100, 32'h0200_0000, "R2 field1 equal");

    // R6/R7: long displacement extremes, relative and absolute, with link
    fire(2'd1, 5'd0, 5'd0, 24'h7F_FFFF, 1'b0, 1'b0, 32'h0100_0000, '0, "R6 long max");
    fire(2'd1, 5'd0, 5'd0, 24'h80_0000, 1'b0, 1'b1, 32'h0300_0000, '0, "R6 long min link R9");
    fire(2'd1, 5'd0, 5'd0, 24'hFF_FFFF, 1'b1, 1'b0, 32'h0000_4000, '0, "R7 long abs neg");
    fire(2'd1, 5'd0, 5'd0, 24'h00_0400, 1'b1, 1'b1, 32'h0000_8000, '0, "R7 long abs link");
    fire(2'd0, 5'd20, 5'd0, 24'hFF_2000, 1'b0, 1'b0, 32'h0001_0000, '0, "R6 short neg upper ignored");
    fire(2'd0, 5'd20, 5'd0, 24'h00_1FFF, 1'b1, 1'b0, 32'h0001_0000, '0, "R7 short abs max");

    // R11/R9: not taken still links
    fire(2'd0, 5'd4, 5'd2, 24'd100, 1'b0, 1'b1, 32'h0000_2000, 32'h2000_0000, "R11 not taken link");

    // R8: to-link with stale lr and with link update in the same branch
    set_lr(32'h0000_5557);
    fire(2'd2, 5'd20, 5'd0, 24'd0, 1'b0, 1'b1, 32'h0000_9000, '0, "R8 to-link old lr");
    fire(2'd2, 5'd0, 5'd3, 24'd0, 1'b0, 1'b0, 32'h0000_9100, '0, "R8 to-link decrement");

    // R8: to-count never decrements and its count test passes
    set_ctr(32'h0000_1003);
    fire(2'd3, 5'd0, 5'd0, 24'd0, 1'b0, 1'b0, 32'h0000_A000, 32'h0000_0000, "R8 to-count");
    fire(2'd3, 5'd0, 5'd0, 24'd0, 1'b0, 1'b0, 32'h0000_A000, 32'hFFFF_FFFF, "R8 to-count bit fail");

    // R4: count wraps from zero
    set_ctr(32'd0);
    fire(2'd0, 5'd16, 5'd0, 24'd4, 1'b0, 1'b0, 32'h0000_B000, '0, "R4 wrap");

    // R3: option bit 0 has no effect
    set_ctr(32'd5);
    fire(2'd0, 5'd17, 5'd0, 24'd4, 1'b0, 1'b0, 32'h0000_C000, '0, "R3 hint bit");

    // R1: idle cycle drops out_valid
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle", 32'(out_valid), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule